// File: doc/BRIEF.md
# Dual-Request Interrupt Controller

This block collects up to 32 interrupt sources and turns them into two request lines and one wake line. Software sets up each source through a small register bus. Each source has a trigger mode, an enable (mask) bit, a wake-enable bit, an input-select bit and a routing bit. The trigger mode is held as a 3-bit code spread over three bit-planes. The input-select bit chooses between the primary line and the alternate line of that source. The routing bit steers the source to request 0 or request 1.

Every source passes through a two-flop synchroniser. Edge events are detected on the synchronised signal and kept in per-source rising and falling latches until software clears them. Level sources show as active only while the synchronised input holds its active level. The two pending vectors show the active, enabled sources on each route. Each request line is the OR of its pending vector. The wake line ignores the mask bit.

Each control field is written through its own set and clear addresses, so one write changes only the bits written as 1 and no read-modify-write is needed. Reads are combinational on the read address.

Top module: `dual_req_intc`

## Requirements
- R1: After reset, the three mode planes, the mask field and the wake field read as all zeros. The route and input-select fields read as all ones. Both edge latches, both pending vectors and the test register read zero. req0, req1 and wake are low.
- R2: The address is {group[3:0], op[1:0]}. Op 0 reads, op 1 sets and op 2 clears. The groups are: 0 mode plane 0, 1 mode plane 1, 2 mode plane 2, 3 mask, 4 wake, 5 route, 6 input-select. A set write ORs wr_data into the field. A clear write removes the bits of wr_data from the field. Bits written as 0 keep their value.
- R3: A read at op 0 returns the current value one cycle after the write. A write to a read-only address (op 0 of any group, or groups 9 and 10) changes no field.
- R4: The mode code {plane2,plane1,plane0} of a source means: 001 rising edge, 010 falling edge, 011 both edges, 101 active-high level, 110 active-low level. Codes 000, 100 and 111 never make the source active, whatever the input does.
- R5: A rising edge is latched only in modes 001 and 011, and a falling edge only in modes 010 and 011. A latched edge keeps the source active after the input returns, until it is cleared. The latch is visible three clock edges after the input changes. The rising latch reads at group 7, the falling latch at group 8.
- R6: A level source is active from the second clock edge after its input reaches the active level, and inactive from the second clock edge after the input leaves it.
- R7: Writing 1s to group 7 op 2 (rising) or group 8 op 2 (falling) removes those latched edges in the next cycle.
- R8: An active, enabled source with route bit 1 appears in pend0 and raises req0. With route bit 0 it appears in pend1 and raises req1. pend0 reads at group 9 and pend1 at group 10.
- R9: A source whose mask bit is 0 never appears in pend0 or pend1 and never raises a request.
- R10: wake is high when any active source has its wake bit set, whatever its mask bit.
- R11: An input-select bit of 1 takes the source from irq_in. A bit of 0 takes it from irq_alt.
- R12: The test register (group 11, op 1 writes and op 0 reads) returns the last value written and has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Primary source lines |
| irq_alt | input | 32 | Alternate source lines |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address {group, op} |
| wr_data | input | 32 | Write data, one bit per source |
| rd_addr | input | 6 | Read address {group, op} |
| rd_data | output | 32 | Read data, combinational |
| pend0 | output | 32 | Pending sources routed to request 0 |
| pend1 | output | 32 | Pending sources routed to request 1 |
| req0 | output | 1 | Request line 0 |
| req1 | output | 1 | Request line 1 |
| wake | output | 1 | Wake line |

## Verification
A register write takes effect at the clock edge that samples it, so the bench reads the field back one cycle later. A level input reaches the pending vectors on the second edge after it changes, and an edge reaches them on the third edge. The bench drives inputs at the falling clock edge and checks the cycle before each deadline as well as the deadline itself, so a result that comes one cycle early or late fails. The random level phase waits three cycles after changing the inputs before it compares pend0, pend1, req0, req1 and wake with values computed from the bench's own model of the fields.

// File: rtl/dual_req_intc_pkg.sv
package dual_req_intc_pkg;

   localparam int ADDR_W     = 6;
   localparam int NUM_FIELDS = 7;

   localparam logic [1:0] OP_RD  = 2'd0;
   localparam logic [1:0] OP_SET = 2'd1;
   localparam logic [1:0] OP_CLR = 2'd2;

   localparam logic [3:0] G_CFG0  = 4'd0;
   localparam logic [3:0] G_CFG1  = 4'd1;
   localparam logic [3:0] G_CFG2  = 4'd2;
   localparam logic [3:0] G_MASK  = 4'd3;
   localparam logic [3:0] G_WAKE  = 4'd4;
   localparam logic [3:0] G_ROUTE = 4'd5;
   localparam logic [3:0] G_SEL   = 4'd6;
   localparam logic [3:0] G_RISE  = 4'd7;
   localparam logic [3:0] G_FALL  = 4'd8;
   localparam logic [3:0] G_PEND0 = 4'd9;
   localparam logic [3:0] G_PEND1 = 4'd10;
   localparam logic [3:0] G_TEST  = 4'd11;

   // fields whose reset value is all ones: route and input-select
   localparam logic [NUM_FIELDS-1:0] FIELD_RST_ONES = 7'b110_0000;

   typedef enum logic [2:0] {
      TRIG_OFF  = 3'b000,
      TRIG_RISE = 3'b001,
      TRIG_FALL = 3'b010,
      TRIG_BOTH = 3'b011,
      TRIG_HIGH = 3'b101,
      TRIG_LOW  = 3'b110
   } trig_e;

   function automatic logic [ADDR_W-1:0] reg_addr(input logic [3:0] grp, input logic [1:0] op);
      return {grp, op};
   endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin : prm_chk
      assert (STAGES >= 2) else $error("intc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/intc_setclr_reg.sv
module intc_setclr_reg #(
   parameter int W        = 32,
   parameter bit RST_ONES = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_m,
   input  logic [W-1:0] clr_m,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= {W{RST_ONES}};
      else        q <= (q & ~clr_m) | set_m;
   end

   // R2
   set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_m != '0) |=> ((($past(set_m)) & ~q) == '0));
   // R2
   clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_m != '0) |=> ((($past(clr_m) & ~$past(set_m)) & q) == '0));
endmodule

// File: rtl/intc_trig.sv
module intc_trig
   import dual_req_intc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] c0,
   input  logic [W-1:0] c1,
   input  logic [W-1:0] c2,
   input  logic [W-1:0] rise_clr,
   input  logic [W-1:0] fall_clr,
   output logic [W-1:0] rise_q,
   output logic [W-1:0] fall_q,
   output logic [W-1:0] active
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise_en, fall_en, hi_en, lo_en;
   logic [W-1:0] rise_ev, fall_ev;

   for (genvar i = 0; i < W; i++) begin : g_dec
      always_comb begin
         rise_en[i] = 1'b0;
         fall_en[i] = 1'b0;
         hi_en[i]   = 1'b0;
         lo_en[i]   = 1'b0;
         case ({c2[i], c1[i], c0[i]})
            TRIG_RISE: rise_en[i] = 1'b1;
            TRIG_FALL: fall_en[i] = 1'b1;
            TRIG_BOTH: begin
               rise_en[i] = 1'b1;
               fall_en[i] = 1'b1;
            end
            TRIG_HIGH: hi_en[i] = 1'b1;
            TRIG_LOW:  lo_en[i] = 1'b1;
            default: ;
         endcase
      end
   end

   assign rise_ev = lvl & ~prev_q & rise_en;
   assign fall_ev = ~lvl & prev_q & fall_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else begin
         prev_q <= lvl;
         rise_q <= (rise_q & ~rise_clr) | rise_ev;
         fall_q <= (fall_q & ~fall_clr) | fall_ev;
      end
   end

   assign active = (rise_q & rise_en) | (fall_q & fall_en)
                 | (hi_en & lvl) | (lo_en & ~lvl);

   // R5
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(rise_q) & ~$past(rise_clr)) & ~rise_q) == '0));
   // R7
   latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_clr != '0) |=> ((fall_q & $past(fall_clr) & ~$past(fall_ev)) == '0));
endmodule

// File: rtl/dual_req_intc.sv
module dual_req_intc
   import dual_req_intc_pkg::*;
#(
   parameter int N_SRC       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic [N_SRC-1:0]  irq_alt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [N_SRC-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [N_SRC-1:0]  rd_data,
   output logic [N_SRC-1:0]  pend0,
   output logic [N_SRC-1:0]  pend1,
   output logic              req0,
   output logic              req1,
   output logic              wake
);
   initial begin : prm_chk
      assert (N_SRC >= 1 && N_SRC <= 32) else $error("dual_req_intc: N_SRC out of range");
   end

   logic [N_SRC-1:0] fld_q [NUM_FIELDS];
   logic [N_SRC-1:0] test_q;
   logic [N_SRC-1:0] raw, lvl, active, rise_q, fall_q, rise_clr, fall_clr;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      logic [N_SRC-1:0] set_m, clr_m;
      assign set_m = (wr_en && wr_addr == reg_addr(4'(f), OP_SET)) ? wr_data : '0;
      assign clr_m = (wr_en && wr_addr == reg_addr(4'(f), OP_CLR)) ? wr_data : '0;
      intc_setclr_reg #(.W(N_SRC), .RST_ONES(FIELD_RST_ONES[f])) i_reg (
         .clk(clk), .rst_n(rst_n), .set_m(set_m), .clr_m(clr_m), .q(fld_q[f]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) test_q <= '0;
      else if (wr_en && wr_addr == reg_addr(G_TEST, OP_SET)) test_q <= wr_data;
   end

   assign rise_clr = (wr_en && wr_addr == reg_addr(G_RISE, OP_CLR)) ? wr_data : '0;
   assign fall_clr = (wr_en && wr_addr == reg_addr(G_FALL, OP_CLR)) ? wr_data : '0;

   assign raw = (irq_in & fld_q[G_SEL]) | (irq_alt & ~fld_q[G_SEL]);

   intc_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(lvl));

   intc_trig #(.W(N_SRC)) i_trig (
      .clk(clk), .rst_n(rst_n), .lvl(lvl),
      .c0(fld_q[G_CFG0]), .c1(fld_q[G_CFG1]), .c2(fld_q[G_CFG2]),
      .rise_clr(rise_clr), .fall_clr(fall_clr),
      .rise_q(rise_q), .fall_q(fall_q), .active(active));

   assign pend0 = active & fld_q[G_MASK] &  fld_q[G_ROUTE];
   assign pend1 = active & fld_q[G_MASK] & ~fld_q[G_ROUTE];
   assign req0  = |pend0;
   assign req1  = |pend1;
   assign wake  = |(active & fld_q[G_WAKE]);

   always_comb begin
      rd_data = '0;
      if (rd_addr[1:0] == OP_RD) begin
         for (int f = 0; f < NUM_FIELDS; f++)
            if (rd_addr[5:2] == 4'(f)) rd_data = fld_q[f];
         case (rd_addr[5:2])
            G_RISE:  rd_data = rise_q;
            G_FALL:  rd_data = fall_q;
            G_PEND0: rd_data = pend0;
            G_PEND1: rd_data = pend1;
            G_TEST:  rd_data = test_q;
            default: ;
         endcase
      end
   end

   // R3
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == reg_addr(G_PEND0, OP_RD))
      |=> ($stable(fld_q[G_MASK]) && $stable(fld_q[G_ROUTE])));
endmodule

// File: tb/test_dual_req_intc.sv
module test_dual_req_intc;
   localparam int  N     = 32;
   localparam time CLK_P = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq_in = '0, irq_alt = '0;
   logic         wr_en = 1'b0;
   logic [5:0]   wr_addr = '0, rd_addr = '0;
   logic [N-1:0] wr_data = '0;
   logic [N-1:0] rd_data, pend0, pend1;
   logic         req0, req1, wake;

   int unsigned checks = 0, fails = 0;
   logic [N-1:0] m_fld [7];

   always #(CLK_P/2) clk = ~clk;

   dual_req_intc i_dual_req_intc (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_alt(irq_alt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .pend0(pend0), .pend1(pend1),
      .req0(req0), .req1(req1), .wake(wake));

   function automatic logic [5:0] ad(input int g, input int op);
      return {4'(g), 2'(op)};
   endfunction

   task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int g, input int op, input logic [N-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ad(g, op); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int g, output logic [N-1:0] v);
      rd_addr = ad(g, 0);
      #1;
      v = rd_data;
   endtask

   function automatic logic [N-1:0] lvl_active(input logic [N-1:0] c0, c1, c2, lv);
      return (c2 & c0 & ~c1 & lv) | (c2 & c1 & ~c0 & ~lv);
   endfunction

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin : watchdog
      #(CLK_P * 150000);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin : stim
      logic [N-1:0] v;
      void'($urandom(32'h5eed_1c07));
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      for (int g = 0; g < 12; g++) begin
         rd(g, v);
         chk($sformatf("R1 reset group %0d", g), v, (g == 5 || g == 6) ? '1 : '0);
      end
      chk("R1 reset req0/req1/wake", {29'd0, req0, req1, wake}, '0);

      // R2 set and clear semantics, R3 readback
      wr(0, 1, 32'h0000_00F0);
      wr(0, 1, 32'h0000_000F);
      rd(0, v); chk("R2 set ORs bits", v, 32'h0000_00FF);
      wr(0, 2, 32'h0000_000F);
      rd(0, v); chk("R2 clear removes bits", v, 32'h0000_00F0);
      wr(0, 2, 32'h0000_00F0);
      rd(0, v); chk("R3 readback after clear", v, '0);

      // R3 writes to read-only addresses
      wr(9, 0, '1);
      wr(3, 0, '1);
      wr(10, 0, '1);
      rd(3, v); chk("R3 mask after read-only writes", v, '0);
      rd(5, v); chk("R3 route after read-only writes", v, '1);

      // R6 high level on bit 3, route 0
      wr(2, 1, 32'h8); wr(0, 1, 32'h8); wr(3, 1, 32'h8);
      irq_in[3] = 1'b1;
      tick(1); chk("R6 high level not yet after one edge", pend0, '0);
      tick(1); chk("R6 high level after two edges", pend0, 32'h8);
      chk("R8 req0 raised", {31'd0, req0}, 32'h1);
      irq_in[3] = 1'b0;
      tick(1); chk("R6 still pending one edge after drop", pend0, 32'h8);
      tick(1); chk("R6 gone two edges after drop", pend0, '0);
      wr(3, 2, 32'h8);

      // R8 low level on bit 4 routed to request 1
      wr(2, 1, 32'h10); wr(1, 1, 32'h10); wr(5, 2, 32'h10); wr(3, 1, 32'h10);
      chk("R8 low level in pend1", pend1, 32'h10);
      chk("R8 not in pend0", pend0, '0);
      chk("R8 req1 raised", {31'd0, req1}, 32'h1);
      rd(10, v); chk("R8 pend1 read address", v, 32'h10);
      irq_in[4] = 1'b1;
      tick(2); chk("R6 low level released", pend1, '0);
      wr(3, 2, 32'h10);

      // R5 rising edge on bit 5
      wr(0, 1, 32'h20); wr(3, 1, 32'h20);
      irq_in[5] = 1'b1;
      tick(2); chk("R5 rise not yet after two edges", pend0, '0);
      tick(1); chk("R5 rise latched after three edges", pend0, 32'h20);
      irq_in[5] = 1'b0;
      tick(5); chk("R5 rise held after input drops", pend0, 32'h20);
      rd(7, v); chk("R5 rise latch read", v, 32'h20);
      rd(8, v); chk("R5 fall not latched in rise mode", v, '0);
      wr(7, 2, 32'h20);
      rd(7, v); chk("R7 rise latch cleared", v, '0);
      chk("R7 pending gone after clear", pend0, '0);
      wr(3, 2, 32'h20);

      // R5 falling edge on bit 6
      wr(1, 1, 32'h40); wr(3, 1, 32'h40);
      irq_in[6] = 1'b1;
      tick(4);
      rd(7, v); chk("R5 rise ignored in fall mode", v, '0);
      chk("R5 no pending on rise in fall mode", pend0, '0);
      irq_in[6] = 1'b0;
      tick(2); chk("R5 fall not yet after two edges", pend0, '0);
      tick(1); chk("R5 fall latched after three edges", pend0, 32'h40);
      wr(8, 2, 32'h40);
      chk("R7 fall clear removes pending", pend0, '0);
      wr(3, 2, 32'h40);

      // R4 both edges on bit 7
      wr(0, 1, 32'h80); wr(1, 1, 32'h80); wr(3, 1, 32'h80);
      irq_in[7] = 1'b1;
      tick(3); chk("R4 both-edge mode rise", pend0, 32'h80);
      wr(7, 2, 32'h80);
      chk("R7 both-edge rise cleared", pend0, '0);
      irq_in[7] = 1'b0;
      tick(3); chk("R4 both-edge mode fall", pend0, 32'h80);
      rd(8, v); chk("R5 fall latch read", v, 32'h80);
      wr(8, 2, 32'h80);
      wr(3, 2, 32'h80);

      // R4 codes 100 (bit 8) and 111 (bit 9)
      wr(2, 1, 32'h300); wr(0, 1, 32'h200); wr(1, 1, 32'h200); wr(3, 1, 32'h300);
      irq_in[9:8] = 2'b11;
      tick(3); chk("R4 codes 100/111 inactive, input high", pend0 | pend1, '0);
      irq_in[9:8] = 2'b00;
      tick(3); chk("R4 codes 100/111 inactive, input low", pend0 | pend1, '0);
      wr(3, 2, 32'h300);

      // R9 / R10 mask gates requests, wake ignores mask (bit 3 in high mode)
      wr(4, 1, 32'h8);
      irq_in[3] = 1'b1;
      tick(3);
      chk("R9 masked source not pending", pend0, '0);
      chk("R9 masked source no request", {31'd0, req0}, '0);
      chk("R10 wake with mask clear", {31'd0, wake}, 32'h1);
      wr(4, 2, 32'h8);
      chk("R10 wake drops with wake bit clear", {31'd0, wake}, '0);
      irq_in[3] = 1'b0;

      // R11 input select on bit 10
      wr(2, 1, 32'h400); wr(0, 1, 32'h400); wr(6, 2, 32'h400); wr(3, 1, 32'h400);
      irq_in[10] = 1'b1;
      tick(3); chk("R11 primary ignored when alternate selected", pend0, '0);
      irq_alt[10] = 1'b1;
      tick(1); chk("R11 alternate not yet after one edge", pend0, '0);
      tick(1); chk("R11 alternate after two edges", pend0, 32'h400);
      wr(6, 1, 32'h400);
      irq_alt[10] = 1'b0;
      tick(3); chk("R11 primary selected again", pend0, 32'h400);
      irq_in[10] = 1'b0;
      wr(3, 2, 32'h400);
      tick(3);

      // R12 test register
      wr(11, 1, 32'hA5);
      rd(11, v); chk("R12 test register readback", v, 32'hA5);
      chk("R12 no effect on outputs", {29'd0, req0, req1, wake}, '0);
      wr(11, 1, '0);
      rd(11, v); chk("R12 test register cleared", v, '0);

      // R2 random set/clear against a bench model
      for (int f = 0; f < 7; f++) rd(f, m_fld[f]);
      for (int it = 0; it < 200; it++) begin
         int f;
         logic [N-1:0] d;
         bit is_set;
         f = $urandom_range(0, 6);
         d = $urandom;
         is_set = $urandom_range(0, 1);
         wr(f, is_set ? 1 : 2, d);
         m_fld[f] = is_set ? (m_fld[f] | d) : (m_fld[f] & ~d);
         rd(f, v);
         chk($sformatf("R2 random field %0d", f), v, m_fld[f]);
      end

      // R4 R6 R8 R9 R10 R11 random level configurations
      wr(7, 2, '1); wr(8, 2, '1);
      for (int it = 0; it < 60; it++) begin
         logic [N-1:0] lv, act;
         for (int f = 0; f < 7; f++) m_fld[f] = $urandom;
         for (int b = 0; b < N; b++) begin
            case ($urandom_range(0, 4))
               0: {m_fld[2][b], m_fld[1][b], m_fld[0][b]} = 3'b000;
               1: {m_fld[2][b], m_fld[1][b], m_fld[0][b]} = 3'b100;
               2: {m_fld[2][b], m_fld[1][b], m_fld[0][b]} = 3'b111;
               3: {m_fld[2][b], m_fld[1][b], m_fld[0][b]} = 3'b101;
               default: {m_fld[2][b], m_fld[1][b], m_fld[0][b]} = 3'b110;
            endcase
         end
         for (int f = 3; f < 7; f++) begin
            wr(f, 2, ~m_fld[f]);
            wr(f, 1, m_fld[f]);
         end
         wr(2, 1, m_fld[2]); wr(0, 2, ~m_fld[0]); wr(1, 2, ~m_fld[1]);
         wr(0, 1, m_fld[0]); wr(1, 1, m_fld[1]); wr(2, 2, ~m_fld[2]);
         irq_in = $urandom;
         irq_alt = $urandom;
         tick(3);
         lv  = (irq_in & m_fld[6]) | (irq_alt & ~m_fld[6]);
         act = lvl_active(m_fld[0], m_fld[1], m_fld[2], lv);
         chk("R8 random pend0", pend0, act & m_fld[3] & m_fld[5]);
         chk("R8 random pend1", pend1, act & m_fld[3] & ~m_fld[5]);
         chk("R9 random requests", {30'd0, req0, req1},
             {30'd0, |(act & m_fld[3] & m_fld[5]), |(act & m_fld[3] & ~m_fld[5])});
         chk("R10 random wake", {31'd0, wake}, {31'd0, |(act & m_fld[4])});
      end

      summary();
      $finish;
   end
endmodule